// File: doc/BRIEF.md
# Converter Fault Supervisor

This block decides when a switching power converter may run. Comparators outside the block turn the analog supply, sense, auxiliary-winding and temperature levels into single-bit flags, and a strobe marks each switching cycle. From these the block produces two outputs. A global enable follows the supply with hysteresis. A gate-inhibit signal holds the PWM stage off while any fault is latched, while the block is not enabled, and for a fixed recovery interval after the last fault has cleared.

Every fault clears by itself, so the converter restarts without help. The supply over-voltage, auxiliary over-voltage and over-current shutdown faults clear when their flag drops. The over-current shutdown only trips after several consecutive flagged switching cycles, so a single spike does not stop the converter. The over-temperature fault stays latched until a separate cool-down flag arrives. It survives loss of enable, so the supply collapses and recharges repeatedly (hiccup) until the die cools. A cause code shows the fault that most recently shut the converter down.

Top module: `fault_supervisor`

## Requirements
- R1: Every flag input passes through a two-stage synchronizer. With all other flags low, raising `sup_above_on_i` before rising edge 0 sets `enable_o` after edge 2, and the change reaches `gate_inhibit_o` one edge later.
- R2: The enable is set by the synchronized turn-on flag and cleared by the synchronized turn-off flag. When both flags are high, the turn-off flag wins. When neither is high, the enable keeps its value.
- R3: `gate_inhibit_o` is a register. It is 1 whenever, on the previous cycle, the enable was 0, any fault latch was set, or the restart countdown was non-zero.
- R4: The supply over-voltage latch follows its synchronized flag. It inhibits the gate while set, and switching resumes without any other input once the flag drops.
- R5: The auxiliary over-voltage latch follows its synchronized flag in the same way. A later over-voltage shuts the converter down again.
- R6: The sense-shutdown latch sets on the CS_CYCLES-th consecutive strobe cycle (default 3) on which the sense flag is also high. A strobe with the flag low resets the run. Cycles without a strobe leave the run unchanged. Once set, the latch clears when the sense flag is low.
- R7: The over-temperature latch sets on the trip flag and clears only on the cool flag. When both flags are high, the trip flag wins. The latch is unaffected by loss of enable, so the gate stays inhibited through repeated enable cycles until the cool flag arrives.
- R8: When no latch is set, a countdown loaded with RESTART_DLY (default 16) runs down. `gate_inhibit_o` is released RESTART_DLY+1 cycles after the last latch clears, provided the enable is high.
- R9: `cause_o` is loaded when a latch newly sets, with these codes: 1 supply over-voltage, 2 auxiliary over-voltage, 3 sense shutdown, 4 over-temperature. If several latches set in the same cycle, the priority is 4, then 1, then 3, then 2. The code is cleared to 0 when the enable rises while no latch is set.
- R10: While `rst_n` is low: `enable_o` is 0, `gate_inhibit_o` is 1, `cause_o` is 0, and all latches and counters are clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous |
| sup_above_on_i | input | 1 | Supply above the turn-on level |
| sup_below_off_i | input | 1 | Supply below the turn-off level |
| sup_ovp_i | input | 1 | Supply over-voltage |
| aux_ovp_i | input | 1 | Sampled auxiliary-winding over-voltage |
| sense_sd_i | input | 1 | Current sense above the shutdown level |
| temp_hot_i | input | 1 | Die temperature at the trip point |
| temp_cool_i | input | 1 | Die temperature back below the release point |
| cycle_stb_i | input | 1 | One-cycle pulse per switching cycle |
| enable_o | output | 1 | Global enable |
| gate_inhibit_o | output | 1 | Holds the PWM gate off when 1 |
| cause_o | output | 3 | Code of the most recent shutdown fault |

## Verification
The assertions assume only that the inputs are stable around the clock edge and that every input, the strobe included, is already a synchronous level in this clock domain. The synchronizers absorb timing but do not remove glitches. The bench applies every input change one nanosecond after a rising edge and holds it for whole cycles. The strobe is a single-cycle pulse with gaps of several cycles, as a switching clock would give. Within those limits, the stimulus drives conflicting flag pairs (turn-on with turn-off, trip with cool, several faults at once) on purpose.

// File: rtl/fault_supervisor.sv
module fault_supervisor #(
  parameter int CS_CYCLES   = 3,
  parameter int RESTART_DLY = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sup_above_on_i,
  input  logic       sup_below_off_i,
  input  logic       sup_ovp_i,
  input  logic       aux_ovp_i,
  input  logic       sense_sd_i,
  input  logic       temp_hot_i,
  input  logic       temp_cool_i,
  input  logic       cycle_stb_i,
  output logic       enable_o,
  output logic       gate_inhibit_o,
  output logic [2:0] cause_o
);
  localparam int CW = $clog2(CS_CYCLES + 1);
  localparam int DW = $clog2(RESTART_DLY + 1);
  localparam logic [CW-1:0] CS_LAST = CW'(CS_CYCLES - 1);
  localparam logic [DW-1:0] DLY_INIT = DW'(RESTART_DLY);

  logic [7:0] meta_q, sync_q;
  wire  [7:0] raw = {cycle_stb_i, temp_cool_i, temp_hot_i, sense_sd_i,
                     aux_ovp_i, sup_ovp_i, sup_below_off_i, sup_above_on_i};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= raw;
      sync_q <= meta_q;
    end

  wire s_on   = sync_q[0];
  wire s_off  = sync_q[1];
  wire s_vov  = sync_q[2];
  wire s_aux  = sync_q[3];
  wire s_cs   = sync_q[4];
  wire s_hot  = sync_q[5];
  wire s_cool = sync_q[6];
  wire s_stb  = sync_q[7];

  logic          vov_q, aux_q, cs_q, ot_q;
  logic [CW-1:0] cs_cnt;
  logic [DW-1:0] dly_q;

  wire any_q   = vov_q | aux_q | cs_q | ot_q;
  wire cs_trip = !cs_q && s_stb && s_cs && (cs_cnt == CS_LAST);
  wire vov_n   = s_vov;
  wire aux_n   = s_aux;
  wire cs_n    = cs_q ? s_cs : cs_trip;
  wire ot_n    = s_hot | (ot_q & ~s_cool);
  wire any_n   = vov_n | aux_n | cs_n | ot_n;
  wire en_n    = s_off ? 1'b0 : (s_on ? 1'b1 : enable_o);

  wire [3:0] fresh = {ot_n & ~ot_q, vov_n & ~vov_q, cs_n & ~cs_q, aux_n & ~aux_q};

  logic [2:0] cause_n;
  always_comb begin
    cause_n = cause_o;
    if (fresh[3])                               cause_n = 3'd4;
    else if (fresh[2])                          cause_n = 3'd1;
    else if (fresh[1])                          cause_n = 3'd3;
    else if (fresh[0])                          cause_n = 3'd2;
    else if (en_n && !enable_o && !any_n)       cause_n = 3'd0;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      vov_q          <= 1'b0;
      aux_q          <= 1'b0;
      cs_q           <= 1'b0;
      ot_q           <= 1'b0;
      cs_cnt         <= '0;
      dly_q          <= '0;
      enable_o       <= 1'b0;
      gate_inhibit_o <= 1'b1;
      cause_o        <= 3'd0;
    end else begin
      vov_q    <= vov_n;
      aux_q    <= aux_n;
      cs_q     <= cs_n;
      ot_q     <= ot_n;
      enable_o <= en_n;
      cause_o  <= cause_n;
      if (cs_q || cs_trip)       cs_cnt <= '0;
      else if (s_stb)            cs_cnt <= s_cs ? cs_cnt + 1'b1 : '0;
      if (any_q)                 dly_q <= DLY_INIT;
      else if (dly_q != '0)      dly_q <= dly_q - 1'b1;
      gate_inhibit_o <= !enable_o || any_q || (dly_q != '0);
    end

  // R3
  not_en_inh_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !enable_o |=> gate_inhibit_o);
  // R3
  fault_inh_chk: assert property (@(posedge clk) disable iff (!rst_n)
    any_q |=> gate_inhibit_o);
  // R2
  en_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    enable_o && !s_off |=> enable_o);
  // R6
  cs_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_cnt < CW'(CS_CYCLES));
  // R7
  ot_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ot_q) |-> $past(s_cool));
  // R8
  release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(gate_inhibit_o) |-> $past(enable_o && !any_q));
  // R9
  cause_ot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ot_q) |-> cause_o == 3'd4);
endmodule

// File: tb/fault_supervisor_tb.sv
module fault_supervisor_tb;
  localparam int NCS = 3;
  localparam int RD  = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic on_f = 0, off_f = 0, vov_f = 0, aux_f = 0, cs_f = 0, hot_f = 0, cool_f = 0, stb_f = 0;
  logic en_o, inh_o;
  logic [2:0] cause;

  always #2 clk = ~clk;

  fault_supervisor #(.CS_CYCLES(NCS), .RESTART_DLY(RD)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .sup_above_on_i(on_f), .sup_below_off_i(off_f), .sup_ovp_i(vov_f),
    .aux_ovp_i(aux_f), .sense_sd_i(cs_f), .temp_hot_i(hot_f),
    .temp_cool_i(cool_f), .cycle_stb_i(stb_f),
    .enable_o(en_o), .gate_inhibit_o(inh_o), .cause_o(cause));

  int total = 0, bad = 0;
  string phase = "R10";
  bit done = 0;

  // behavioural reference: delayed copies of inputs, fault flags, counters
  bit [7:0] d1 = 0, d2 = 0;
  bit m_en = 0, m_inh = 1, f_v = 0, f_a = 0, f_c = 0, f_t = 0;
  int m_run = 0, m_wait = 0, m_cause = 0;

  task automatic check(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_step();
    bit any_old, nv, na, nc, nt, ne, any_new;
    any_old = f_v | f_a | f_c | f_t;
    m_inh = !m_en || any_old || (m_wait > 0);
    if (any_old) m_wait = RD; else if (m_wait > 0) m_wait--;
    nv = d2[2];
    na = d2[3];
    if (f_c) begin nc = d2[4]; m_run = 0; end
    else if (d2[7]) begin
      if (d2[4]) m_run++; else m_run = 0;
      nc = (m_run == NCS);
      if (nc) m_run = 0;
    end else nc = 0;
    nt = d2[5] ? 1 : (d2[6] ? 0 : f_t);
    ne = d2[1] ? 0 : (d2[0] ? 1 : m_en);
    any_new = nv | na | nc | nt;
    if (nt && !f_t) m_cause = 4;
    else if (nv && !f_v) m_cause = 1;
    else if (nc && !f_c) m_cause = 3;
    else if (na && !f_a) m_cause = 2;
    else if (ne && !m_en && !any_new) m_cause = 0;
    f_v = nv; f_a = na; f_c = nc; f_t = nt; m_en = ne;
    d2 = d1;
    d1 = {stb_f, cool_f, hot_f, cs_f, aux_f, vov_f, off_f, on_f};
  endtask

  task automatic tick(int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #1;
      model_step();
      check({phase, " enable"}, en_o, m_en);
      check({phase, " inhibit"}, inh_o, m_inh);
      check({phase, " cause"}, cause, m_cause);
    end
  endtask

  task automatic strobes(int n, bit flag);
    for (int i = 0; i < n; i++) begin
      cs_f = flag; stb_f = 1; tick(1);
      stb_f = 0; tick(3);
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R10 reset values
    check("R10 enable", en_o, 0);
    check("R10 inhibit", inh_o, 1);
    check("R10 cause", cause, 0);
    rst_n = 1;
    phase = "R1";
    on_f = 1;
    tick(2);
    check("R1 enable before sync", en_o, 0);
    tick(1);
    check("R1 enable after two flops", en_o, 1);
    tick(1);
    check("R1 inhibit released", inh_o, 0);
    phase = "R2";
    on_f = 0; tick(6);
    check("R2 hold between levels", en_o, 1);
    off_f = 1; on_f = 1; tick(5);
    check("R2 turn-off wins", en_o, 0);
    off_f = 0; tick(6);
    phase = "R3"; tick(4);
    phase = "R4";
    vov_f = 1; tick(5); vov_f = 0; tick(RD + 6);
    check("R4 auto restart", inh_o, 0);
    phase = "R5";
    aux_f = 1; tick(3); aux_f = 0; tick(RD + 6);
    aux_f = 1; tick(4);
    check("R5 second shutdown", inh_o, 1);
    aux_f = 0; tick(RD + 6);
    phase = "R6";
    strobes(2, 1); strobes(1, 0); strobes(2, 1);
    check("R6 run broken, no trip", inh_o, 0);
    cs_f = 1; tick(20);
    check("R6 no strobe, no trip", inh_o, 0);
    strobes(1, 1);
    check("R6 trip on third strobe", inh_o, 1);
    check("R9 sense cause", cause, 3);
    cs_f = 0; tick(RD + 6);
    phase = "R7";
    hot_f = 1; tick(2); hot_f = 0; tick(30);
    check("R7 latched without cool", inh_o, 1);
    off_f = 1; tick(6); off_f = 0; on_f = 1; tick(6); on_f = 0; tick(RD + 8);
    check("R7 hiccup keeps gate off", inh_o, 1);
    check("R9 temp cause kept", cause, 4);
    hot_f = 1; cool_f = 1; tick(4); hot_f = 0; tick(4); cool_f = 0;
    phase = "R8";
    tick(RD + 6);
    check("R8 release after delay", inh_o, 0);
    phase = "R9";
    vov_f = 1; aux_f = 1; cs_f = 0; tick(5);
    check("R9 simultaneous priority", cause, 1);
    vov_f = 0; aux_f = 0; tick(RD + 4);
    off_f = 1; tick(5); off_f = 0; on_f = 1; tick(5);
    check("R9 cleared on clean enable", cause, 0);
    on_f = 0; tick(RD + 4);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule